// File: doc/BRIEF.md
# Execute-Stage Operand Bypass Unit

This block chooses where the two ALU operands of the execute stage of a five-stage in-order pipeline come from. The instruction in execute names two source registers: the first feeds operand A and the second feeds operand B. Two older instructions may still hold results that have not yet been written to the register file. One sits in the execute/memory pipeline register and the other in the memory/write-back pipeline register. For each operand the block compares the source register number with the destination number of each older stage. It then drives a 2-bit select code and the selected data word, so the value read from the register file is bypassed whenever a newer result is pending.

The block is purely combinational and holds no state. Both outputs follow the present inputs within the same cycle. The case where a load is followed at once by an instruction that uses its result cannot be covered by a bypass. That case belongs to a separate hazard unit, which holds the consumer back for one cycle. By the time this block sees the consumer, the loaded value sits in the memory/write-back stage and is picked up by the normal comparison.

Top module: `exec_bypass_unit`

## Requirements
- R1: When neither older stage qualifies for an operand, its select code is 00 and the operand equals that operand's register-file read value.
- R2: When the execute/memory stage has its write flag set, a non-zero destination, and a destination equal to the operand's source register, the select code is 10 and the operand equals the execute/memory result.
- R3: When only the memory/write-back stage qualifies under the same conditions, the select code is 01 and the operand equals the memory/write-back result.
- R4: When both stages qualify for the same operand, the execute/memory stage wins: select code 10 and the execute/memory result.
- R5: A stage whose write flag is clear is never forwarded from, whatever its destination number is.
- R6: A destination of register 0 is never forwarded from, so a source register of 0 always gives select code 00.
- R7: Operand A is decided only from the first source register and operand B only from the second, so the two selects may differ in the same cycle.
- R8: Select code 11 is never produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_a_idx | input | REG_AW | Source register number for operand A (instruction in execute) |
| src_b_idx | input | REG_AW | Source register number for operand B (instruction in execute) |
| rf_a_val | input | DATA_W | Register-file read value for operand A |
| rf_b_val | input | DATA_W | Register-file read value for operand B |
| exm_dst_idx | input | REG_AW | Destination register number held in execute/memory |
| exm_wr_en | input | 1 | Register-write flag held in execute/memory |
| exm_result | input | DATA_W | Result held in execute/memory |
| mwb_dst_idx | input | REG_AW | Destination register number held in memory/write-back |
| mwb_wr_en | input | 1 | Register-write flag held in memory/write-back |
| mwb_result | input | DATA_W | Result held in memory/write-back |
| sel_a | output | 2 | Operand A source: 00 register file, 01 memory/write-back, 10 execute/memory |
| sel_b | output | 2 | Operand B source, same encoding as sel_a |
| opnd_a | output | DATA_W | Selected operand A |
| opnd_b | output | DATA_W | Selected operand B |

## Verification
Every result of this block is due in the same cycle as its stimulus: no register lies between an input and either select or operand. The bench changes inputs just after a rising edge and reads the outputs at the following falling edge, half a period later. By then the combinational paths have settled, and no edge ordering can affect the read. Directed cases cover each priority and each disqualifying condition. Random cases draw register numbers from a small range, so that matches on one stage, on both stages and on register 0 occur often.

// File: rtl/exec_bypass_pkg.sv
package exec_bypass_pkg;

    typedef enum logic [1:0] {
        SRC_REGFILE = 2'b00,
        SRC_MEMWB   = 2'b01,
        SRC_EXMEM   = 2'b10
    } opnd_src_e;

endpackage

// File: rtl/bypass_stage_match.sv
module bypass_stage_match #(
    parameter int REG_AW = 5
) (
    input  logic [REG_AW-1:0] src_idx,
    input  logic [REG_AW-1:0] dst_idx,
    input  logic              wr_en,
    output logic              hit
);
    localparam logic [REG_AW-1:0] ZERO_REG = '0;

    always_comb begin
        hit = wr_en && (dst_idx != ZERO_REG) && (dst_idx == src_idx);
    end
endmodule

// File: rtl/bypass_priority.sv
module bypass_priority
    import exec_bypass_pkg::*;
(
    input  logic      exm_hit,
    input  logic      mwb_hit,
    output opnd_src_e src_sel
);
    always_comb begin
        unique case ({exm_hit, mwb_hit})
            2'b10, 2'b11: src_sel = SRC_EXMEM;
            2'b01:        src_sel = SRC_MEMWB;
            default:      src_sel = SRC_REGFILE;
        endcase
    end
endmodule

// File: rtl/bypass_data_mux.sv
module bypass_data_mux
    import exec_bypass_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  opnd_src_e         src_sel,
    input  logic [DATA_W-1:0] rf_val,
    input  logic [DATA_W-1:0] exm_val,
    input  logic [DATA_W-1:0] mwb_val,
    output logic [DATA_W-1:0] opnd
);
    always_comb begin
        unique case (src_sel)
            SRC_EXMEM: opnd = exm_val;
            SRC_MEMWB: opnd = mwb_val;
            default:   opnd = rf_val;
        endcase
    end
endmodule

// File: rtl/exec_bypass_unit.sv
module exec_bypass_unit
    import exec_bypass_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int REG_AW = 5
) (
    input  logic [REG_AW-1:0] src_a_idx,
    input  logic [REG_AW-1:0] src_b_idx,
    input  logic [DATA_W-1:0] rf_a_val,
    input  logic [DATA_W-1:0] rf_b_val,
    input  logic [REG_AW-1:0] exm_dst_idx,
    input  logic              exm_wr_en,
    input  logic [DATA_W-1:0] exm_result,
    input  logic [REG_AW-1:0] mwb_dst_idx,
    input  logic              mwb_wr_en,
    input  logic [DATA_W-1:0] mwb_result,
    output logic [1:0]        sel_a,
    output logic [1:0]        sel_b,
    output logic [DATA_W-1:0] opnd_a,
    output logic [DATA_W-1:0] opnd_b
);
    localparam int N_OPND = 2;

    logic [REG_AW-1:0] src_idx [N_OPND];
    logic [DATA_W-1:0] rf_val  [N_OPND];
    logic [DATA_W-1:0] opnd    [N_OPND];
    opnd_src_e         src_sel [N_OPND];
    logic              exm_hit [N_OPND];
    logic              mwb_hit [N_OPND];

    always_comb begin
        src_idx[0] = src_a_idx;
        src_idx[1] = src_b_idx;
        rf_val[0]  = rf_a_val;
        rf_val[1]  = rf_b_val;
    end

    for (genvar g = 0; g < N_OPND; g++) begin : g_opnd
        bypass_stage_match #(.REG_AW(REG_AW)) u_exm_match (
            .src_idx (src_idx[g]),
            .dst_idx (exm_dst_idx),
            .wr_en   (exm_wr_en),
            .hit     (exm_hit[g])
        );

        bypass_stage_match #(.REG_AW(REG_AW)) u_mwb_match (
            .src_idx (src_idx[g]),
            .dst_idx (mwb_dst_idx),
            .wr_en   (mwb_wr_en),
            .hit     (mwb_hit[g])
        );

        bypass_priority u_prio (
            .exm_hit (exm_hit[g]),
            .mwb_hit (mwb_hit[g]),
            .src_sel (src_sel[g])
        );

        bypass_data_mux #(.DATA_W(DATA_W)) u_mux (
            .src_sel (src_sel[g]),
            .rf_val  (rf_val[g]),
            .exm_val (exm_result),
            .mwb_val (mwb_result),
            .opnd    (opnd[g])
        );
    end

    always_comb begin
        sel_a  = src_sel[0];
        sel_b  = src_sel[1];
        opnd_a = opnd[0];
        opnd_b = opnd[1];
    end
endmodule

// File: rtl/exec_bypass_checker.sv
module exec_bypass_checker #(
    parameter int DATA_W = 32,
    parameter int REG_AW = 5
) (
    input logic [REG_AW-1:0] src_a_idx,
    input logic [REG_AW-1:0] src_b_idx,
    input logic [DATA_W-1:0] rf_a_val,
    input logic [DATA_W-1:0] rf_b_val,
    input logic [REG_AW-1:0] exm_dst_idx,
    input logic              exm_wr_en,
    input logic [DATA_W-1:0] exm_result,
    input logic [REG_AW-1:0] mwb_dst_idx,
    input logic              mwb_wr_en,
    input logic [DATA_W-1:0] mwb_result,
    input logic [1:0]        sel_a,
    input logic [1:0]        sel_b,
    input logic [DATA_W-1:0] opnd_a,
    input logic [DATA_W-1:0] opnd_b
);
    logic known;

    always_comb begin
        known = !$isunknown({src_a_idx, src_b_idx, rf_a_val, rf_b_val,
                             exm_dst_idx, exm_wr_en, exm_result,
                             mwb_dst_idx, mwb_wr_en, mwb_result,
                             sel_a, sel_b, opnd_a, opnd_b});
        if (known) begin
            AST_NO_CODE11_A: assert (sel_a != 2'b11);                                  // R8
            AST_NO_CODE11_B: assert (sel_b != 2'b11);                                  // R8
            AST_RF_PATH_A: assert (sel_a != 2'b00 || opnd_a == rf_a_val);              // R1
            AST_RF_PATH_B: assert (sel_b != 2'b00 || opnd_b == rf_b_val);              // R1
            AST_EXM_PATH_A: assert (sel_a != 2'b10 || opnd_a == exm_result);           // R2
            AST_EXM_PATH_B: assert (sel_b != 2'b10 || opnd_b == exm_result);           // R2
            AST_MWB_PATH_A: assert (sel_a != 2'b01 || opnd_a == mwb_result);           // R3
            AST_MWB_PATH_B: assert (sel_b != 2'b01 || opnd_b == mwb_result);           // R3
            AST_EXM_WINS_A: assert (!(exm_wr_en && exm_dst_idx == src_a_idx
                                      && src_a_idx != '0) || sel_a == 2'b10);          // R4
            AST_NOWR_EXM_A: assert (exm_wr_en || sel_a != 2'b10);                      // R5
            AST_NOWR_MWB_B: assert (mwb_wr_en || sel_b != 2'b01);                      // R5
            AST_ZERO_SRC_A: assert (src_a_idx != '0 || sel_a == 2'b00);                // R6
            AST_ZERO_SRC_B: assert (src_b_idx != '0 || sel_b == 2'b00);                // R6
        end
    end
endmodule

bind exec_bypass_unit exec_bypass_checker #(.DATA_W(DATA_W), .REG_AW(REG_AW)) u_chk (.*);

// File: tb/exec_bypass_unit_bench.sv
`timescale 1ns/1ps
module exec_bypass_unit_bench;
    localparam int DATA_W = 32;
    localparam int REG_AW = 5;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic [REG_AW-1:0] src_a_idx, src_b_idx, exm_dst_idx, mwb_dst_idx;
    logic [DATA_W-1:0] rf_a_val, rf_b_val, exm_result, mwb_result;
    logic              exm_wr_en, mwb_wr_en;
    logic [1:0]        sel_a, sel_b;
    logic [DATA_W-1:0] opnd_a, opnd_b;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    exec_bypass_unit #(.DATA_W(DATA_W), .REG_AW(REG_AW)) u_exec_bypass_unit (.*);

    function automatic logic [1:0] want_sel(input logic [REG_AW-1:0] src);
        if (exm_wr_en && exm_dst_idx != 0 && exm_dst_idx == src) return 2'b10;
        if (mwb_wr_en && mwb_dst_idx != 0 && mwb_dst_idx == src) return 2'b01;
        return 2'b00;
    endfunction

    function automatic logic [DATA_W-1:0] want_val(input logic [1:0] s,
                                                    input logic [DATA_W-1:0] rf);
        if (s == 2'b10) return exm_result;
        if (s == 2'b01) return mwb_result;
        return rf;
    endfunction

    task automatic chk(input string tag, input logic [DATA_W-1:0] got,
                       input logic [DATA_W-1:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic apply(input logic [REG_AW-1:0] sa, input logic [REG_AW-1:0] sb,
                         input logic [REG_AW-1:0] ed, input logic ew,
                         input logic [REG_AW-1:0] md, input logic mw);
        @(posedge clk);
        src_a_idx = sa; src_b_idx = sb;
        exm_dst_idx = ed; exm_wr_en = ew;
        mwb_dst_idx = md; mwb_wr_en = mw;
        rf_a_val = $urandom; rf_b_val = $urandom;
        exm_result = $urandom; mwb_result = $urandom;
        @(negedge clk);
    endtask

    task automatic check_both(input string tag);
        logic [1:0] ea, eb;
        ea = want_sel(src_a_idx);
        eb = want_sel(src_b_idx);
        chk({tag, " sel_a"}, DATA_W'(sel_a), DATA_W'(ea));
        chk({tag, " sel_b"}, DATA_W'(sel_b), DATA_W'(eb));
        chk({tag, " opnd_a"}, opnd_a, want_val(ea, rf_a_val));
        chk({tag, " opnd_b"}, opnd_b, want_val(eb, rf_b_val));
    endtask

    initial begin
        int cyc = 0;
        while (!done) begin
            @(posedge clk);
            cyc++;
            if (cyc > 20000) begin
                total++; bad++;
                $display("FAIL watchdog expired");
                $display("test done: total=%0d bad=%0d", total, bad);
                $finish;
            end
        end
    end

    initial begin
        void'($urandom(32'd4242));
        src_a_idx = '0; src_b_idx = '0; exm_dst_idx = '0; mwb_dst_idx = '0;
        exm_wr_en = 1'b0; mwb_wr_en = 1'b0;
        rf_a_val = 32'h1111_0000; rf_b_val = 32'h2222_0000;
        exm_result = 32'hE0E0_E0E0; mwb_result = 32'hB0B0_B0B0;
        @(negedge clk);
        // idle state after start-up: register file on both operands
        chk("R1 idle sel_a", DATA_W'(sel_a), 0);
        chk("R1 idle opnd_b", opnd_b, 32'h2222_0000);

        apply(5'd3, 5'd4, 5'd7, 1'b1, 5'd8, 1'b1);
        check_both("R1 no match");
        apply(5'd3, 5'd4, 5'd3, 1'b1, 5'd9, 1'b1);
        check_both("R2 exm on A");
        chk("R2 exm sel_a code", DATA_W'(sel_a), 2);
        apply(5'd3, 5'd4, 5'd9, 1'b1, 5'd4, 1'b1);
        check_both("R3 mwb on B");
        chk("R3 mwb sel_b code", DATA_W'(sel_b), 1);
        apply(5'd6, 5'd6, 5'd6, 1'b1, 5'd6, 1'b1);
        check_both("R4 both stages");
        chk("R4 priority value", opnd_a, exm_result);
        apply(5'd6, 5'd6, 5'd6, 1'b0, 5'd6, 1'b1);
        check_both("R5 exm write clear");
        chk("R5 fall back to mwb", DATA_W'(sel_a), 1);
        apply(5'd6, 5'd6, 5'd6, 1'b0, 5'd6, 1'b0);
        check_both("R5 both write clear");
        chk("R5 rf value", opnd_b, rf_b_val);
        apply(5'd0, 5'd0, 5'd0, 1'b1, 5'd0, 1'b1);
        check_both("R6 register zero");
        chk("R6 zero sel_a", DATA_W'(sel_a), 0);
        apply(5'd10, 5'd11, 5'd10, 1'b1, 5'd11, 1'b1);
        check_both("R7 split sources");
        chk("R7 sel_b from second source", DATA_W'(sel_b), 1);

        for (int i = 0; i < 400; i++) begin
            apply(REG_AW'($urandom_range(0, 3)), REG_AW'($urandom_range(0, 3)),
                  REG_AW'($urandom_range(0, 3)), 1'($urandom),
                  REG_AW'($urandom_range(0, 3)), 1'($urandom));
            check_both("R1..R7 random");
            chk("R8 no code 11", DATA_W'((sel_a == 2'b11) || (sel_b == 2'b11)), 0);
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule